// File: doc/BRIEF.md
# Permission Downgrade Flush Sequencer

This block sequences permission revocation for a single accelerator that sits behind a physically indexed permission table. The table packs two permission bits per physical page into blocks. A downgrade command names a page and the permission bits to keep. The sequencer reads the block that holds the page and decides from the page's stored write bit whether dirty lines can exist in the accelerator. If the write bit is clear it rewrites the entry at once. If the write bit is set it first has the accelerator flush that page or its whole cache. Only after the flush does it rewrite the entry, or it invalidates everything and clears the table.

A process-complete command flushes the whole accelerator cache. It then invalidates the permission cache and the TLB, and clears the table region one block per cycle so that the next process starts with no permissions. A flush that never ends is cut off by a programmable timeout. The sequence then goes on and a status bit records the event. The block does not decide when a downgrade is needed.

Top module: `perm_revoke_seq`

## Requirements
- R1: After reset `busy`, `flush_req`, `tbl_wr_en`, `tbl_rd_en`, `pc_upd_valid`, `pc_inv_all`, `tlb_inv_all` and `timeout_flag` are all low.
- R2: A command is taken only when `cmd_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until the sequence ends. A command presented while busy has no effect.
- R3: A downgrade (`cmd_op`=0) reads block `cfg_base + page>>PPB_LOG2`, modulo the table size. Page slot s sits at bits [2s+1:2s], with bit 2s = read and bit 2s+1 = write. The new slot value is old AND `cmd_keep`. If this removes no bit, no flush, table write or cache update takes place.
- R4: If bits are removed and the stored write bit is clear, the slot is rewritten without any flush. The permission cache gets `pc_upd_valid` with the page and the new two bits in the same cycle as the table write.
- R5: If bits are removed and the stored write bit is set, `flush_req` is raised first and held until `flush_done`. `flush_all` equals `cmd_whole` and `flush_page` equals the page. No table write happens while `flush_req` is high.
- R6: After a per-page flush (`cmd_whole`=0), only the target slot of the block changes. The other slots keep their bits, and one permission cache update is issued.
- R7: After a whole-cache flush for a downgrade (`cmd_whole`=1), `pc_inv_all` and `tlb_inv_all` pulse for one cycle. Blocks `cfg_base` to `cfg_base+cfg_bound-1` are then written with zero, one per cycle, and no per-page update is issued.
- R8: A process-complete command (`cmd_op`=1) flushes with `flush_all`=1, then invalidates, then zeroes the `cfg_bound` blocks from `cfg_base`. With `cfg_bound`=0 no table write occurs.
- R9: A flush with no `flush_done` ends after `cfg_timeout`+1 cycles of `flush_req`. The sequence then continues as if the flush had completed and `timeout_flag` is set. A `flush_done` in the expiry cycle wins and leaves the flag clear. The flag clears when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = downgrade, 1 = process complete |
| cmd_page | input | PAGE_W | Page index for a downgrade |
| cmd_keep | input | 2 | Permission bits to keep (bit0 read, bit1 write) |
| cmd_whole | input | 1 | Downgrade uses a whole-cache flush and a table clear |
| cfg_base | input | ADDR_W | First table block |
| cfg_bound | input | ADDR_W+1 | Number of table blocks |
| cfg_timeout | input | TMO_W | Flush timeout in cycles |
| busy | output | 1 | Sequence in progress |
| timeout_flag | output | 1 | Last flush ended by timeout |
| flush_req | output | 1 | Flush request to the accelerator |
| flush_all | output | 1 | Flush the whole cache |
| flush_page | output | PAGE_W | Page to flush |
| flush_done | input | 1 | Flush finished |
| tbl_rd_en | output | 1 | Table read strobe, data one cycle later |
| tbl_rd_addr | output | ADDR_W | Table read block |
| tbl_rd_data | input | DW | Table read data |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_addr | output | ADDR_W | Table write block |
| tbl_wr_data | output | DW | Table write data |
| pc_upd_valid | output | 1 | Permission cache entry update |
| pc_upd_page | output | PAGE_W | Page being updated |
| pc_upd_perm | output | 2 | New permission bits |
| pc_inv_all | output | 1 | Invalidate the whole permission cache |
| tlb_inv_all | output | 1 | Invalidate the accelerator TLB |

## Verification
The flush wait can end in two ways in the same cycle: the accelerator's `flush_done` can arrive in exactly the cycle the timeout counter expires. The bench sweeps the responder's latency across the timeout value, both below it and exactly at it, and also uses a responder that never answers. For each case it counts the cycles `flush_req` stays high and reads `timeout_flag`. At equality it expects the flag clear with `cfg_timeout`+1 request cycles. Without an answer it expects the same cycle count with the flag set. In every case the table update must still land.

// File: rtl/perm_revoke_seq.sv
module perm_revoke_seq #(
  parameter int ADDR_W   = 10,
  parameter int PPB_LOG2 = 3,
  parameter int TMO_W    = 12,
  localparam int PAGE_W  = ADDR_W + PPB_LOG2,
  localparam int DW      = 2 << PPB_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [1:0]        cmd_keep,
  input  logic              cmd_whole,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_bound,
  input  logic [TMO_W-1:0]  cfg_timeout,
  output logic              busy,
  output logic              timeout_flag,
  output logic              flush_req,
  output logic              flush_all,
  output logic [PAGE_W-1:0] flush_page,
  input  logic              flush_done,
  output logic              tbl_rd_en,
  output logic [ADDR_W-1:0] tbl_rd_addr,
  input  logic [DW-1:0]     tbl_rd_data,
  output logic              tbl_wr_en,
  output logic [ADDR_W-1:0] tbl_wr_addr,
  output logic [DW-1:0]     tbl_wr_data,
  output logic              pc_upd_valid,
  output logic [PAGE_W-1:0] pc_upd_page,
  output logic [1:0]        pc_upd_perm,
  output logic              pc_inv_all,
  output logic              tlb_inv_all
);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_EVAL, S_FLUSH, S_INV, S_ZERO, S_UPD
  } state_t;

  state_t              state;
  logic                op_q, whole_q, timeout_q;
  logic [PAGE_W-1:0]   page_q;
  logic [1:0]          keep_q;
  logic [DW-1:0]       word_q;
  logic [TMO_W-1:0]    tmo_cnt;
  logic [ADDR_W:0]     zcnt;

  logic [PPB_LOG2-1:0] sidx;
  logic [PPB_LOG2:0]   sbit;
  logic [1:0]          rd_slot, cur_slot, new_slot;
  logic                accept;

  assign sidx     = page_q[PPB_LOG2-1:0];
  assign sbit     = {sidx, 1'b0};
  assign rd_slot  = tbl_rd_data[sbit +: 2];
  assign cur_slot = word_q[sbit +: 2];
  assign new_slot = cur_slot & keep_q;
  assign accept   = cmd_valid && (state == S_IDLE);

  assign busy         = (state != S_IDLE);
  assign timeout_flag = timeout_q;
  assign flush_req    = (state == S_FLUSH);
  assign flush_all    = op_q | whole_q;
  assign flush_page   = page_q;
  assign tbl_rd_en    = (state == S_RD);
  assign tbl_rd_addr  = cfg_base + page_q[PAGE_W-1:PPB_LOG2];
  assign tbl_wr_en    = (state == S_UPD) || (state == S_ZERO);
  assign tbl_wr_addr  = (state == S_ZERO) ? cfg_base + zcnt[ADDR_W-1:0] : tbl_rd_addr;
  assign tbl_wr_data  = (state == S_ZERO) ? '0 :
                        ((word_q & ~(DW'(2'b11) << sbit)) | (DW'(new_slot) << sbit));
  assign pc_upd_valid = (state == S_UPD);
  assign pc_upd_page  = page_q;
  assign pc_upd_perm  = new_slot;
  assign pc_inv_all   = (state == S_INV);
  assign tlb_inv_all  = (state == S_INV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= 1'b0;
      whole_q   <= 1'b0;
      timeout_q <= 1'b0;
      page_q    <= '0;
      keep_q    <= '0;
      word_q    <= '0;
      tmo_cnt   <= '0;
      zcnt      <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q      <= cmd_op;
          whole_q   <= cmd_whole;
          page_q    <= cmd_page;
          keep_q    <= cmd_keep;
          timeout_q <= 1'b0;
          tmo_cnt   <= '0;
          state     <= cmd_op ? S_FLUSH : S_RD;
        end
        S_RD: state <= S_EVAL;
        S_EVAL: begin
          word_q <= tbl_rd_data;
          if ((rd_slot & ~keep_q) == 2'b00) state <= S_IDLE;
          else if (rd_slot[1])              state <= S_FLUSH;
          else                              state <= S_UPD;
        end
        S_FLUSH: begin
          if (flush_done || tmo_cnt == cfg_timeout) begin
            if (!flush_done) timeout_q <= 1'b1;
            state <= (op_q || whole_q) ? S_INV : S_UPD;
          end
          tmo_cnt <= tmo_cnt + 1'b1;
        end
        S_INV: begin
          zcnt  <= '0;
          state <= (cfg_bound == '0) ? S_IDLE : S_ZERO;
        end
        S_ZERO: begin
          if (zcnt == cfg_bound - 1'b1) state <= S_IDLE;
          zcnt <= zcnt + 1'b1;
        end
        S_UPD:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R5
  no_write_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_req && tbl_wr_en));

  // R9
  flush_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_req) |-> ($past(flush_done) || timeout_flag));

  // R9
  timeout_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> ($past(flush_req) && !$past(flush_done)));

  // R7
  inv_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pc_inv_all) |-> $past(flush_req));

  // R4
  upd_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_upd_valid |-> (tbl_wr_en && tbl_wr_data != '0 || pc_upd_perm == 2'b00 || tbl_wr_en));

endmodule

// File: tb/perm_revoke_seq_tb_top.sv
`timescale 1ns/1ps
module perm_revoke_seq_tb_top;
  localparam int AW = 3, PL = 2, TW = 8;
  localparam int PW = AW + PL, DW = 2 << PL, NB = 1 << AW;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_op = 0, cmd_whole = 0;
  logic [PW-1:0] cmd_page = '0;
  logic [1:0] cmd_keep = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW:0] cfg_bound = 6;
  logic [TW-1:0] cfg_timeout = 10;
  logic busy, timeout_flag, flush_req, flush_all, flush_done;
  logic [PW-1:0] flush_page, pc_upd_page;
  logic tbl_rd_en, tbl_wr_en, pc_upd_valid, pc_inv_all, tlb_inv_all;
  logic [AW-1:0] tbl_rd_addr, tbl_wr_addr;
  logic [DW-1:0] tbl_rd_data, tbl_wr_data;
  logic [1:0] pc_upd_perm;

  perm_revoke_seq #(.ADDR_W(AW), .PPB_LOG2(PL), .TMO_W(TW)) dut_i (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_page, .cmd_keep, .cmd_whole,
    .cfg_base, .cfg_bound, .cfg_timeout, .busy, .timeout_flag, .flush_req,
    .flush_all, .flush_page, .flush_done, .tbl_rd_en, .tbl_rd_addr, .tbl_rd_data,
    .tbl_wr_en, .tbl_wr_addr, .tbl_wr_data, .pc_upd_valid, .pc_upd_page,
    .pc_upd_perm, .pc_inv_all, .tlb_inv_all);

  logic [DW-1:0] mem [NB];
  logic [DW-1:0] exp_mem [NB];
  always @(posedge clk) begin
    if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];
    if (tbl_wr_en) mem[tbl_wr_addr] <= tbl_wr_data;
  end

  int resp_lat = 2, fcnt = 0;
  initial flush_done = 0;
  always @(negedge clk) begin
    if (!flush_req) begin fcnt <= 0; flush_done <= 0; end
    else begin flush_done <= (fcnt == resp_lat); fcnt <= fcnt + 1; end
  end

  int n_fl, n_upd, n_inv, n_tlb, n_wr, n_wrfl, last_upd_perm;
  logic seen_all;
  always @(negedge clk) begin
    if (flush_req) begin n_fl++; seen_all = flush_all; end
    if (pc_upd_valid) begin n_upd++; last_upd_perm = pc_upd_perm; end
    if (pc_inv_all) n_inv++;
    if (tlb_inv_all) n_tlb++;
    if (tbl_wr_en) n_wr++;
    if (tbl_wr_en && flush_req) n_wrfl++;
  end

  int tests = 0, fails = 0;
  bit done_flag = 0;
  task automatic check(string req, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clr_counts();
    n_fl = 0; n_upd = 0; n_inv = 0; n_tlb = 0; n_wr = 0; n_wrfl = 0; seen_all = 0;
  endtask

  task automatic preload(int seed);
    for (int i = 0; i < NB; i++) begin
      mem[i] = DW'(8'h3C + (i + seed) * 37);
      exp_mem[i] = mem[i];
    end
  endtask

  task automatic run_cmd(logic op, int page, int keep, logic whole);
    @(negedge clk);
    clr_counts();
    cmd_valid = 1; cmd_op = op; cmd_page = PW'(page); cmd_keep = 2'(keep); cmd_whole = whole;
    @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic cmp_mem(string req);
    int bad = 0;
    for (int i = 0; i < NB; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(req, bad, 0);
  endtask

  function automatic int blk(int page);
    return (int'(cfg_base) + (page >> PL)) % NB;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    preload(0);
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 flush_req", flush_req, 0);
    check("R1 tbl_wr_en", tbl_wr_en, 0);
    check("R1 tbl_rd_en", tbl_rd_en, 0);
    check("R1 inv", pc_inv_all | tlb_inv_all | pc_upd_valid, 0);
    check("R1 timeout_flag", timeout_flag, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5 R6 R7 sweep
    for (int pi = 0; pi < 3; pi++) begin
      for (int old = 0; old < 4; old++) begin
        for (int keep = 0; keep < 4; keep++) begin
          for (int wh = 0; wh < 2; wh++) begin
            int page, b, s, rm, nw;
            page = (pi == 0) ? 0 : (pi == 1) ? 13 : 31;
            b = blk(page); s = page % (1 << PL);
            preload(old + keep * 4 + pi);
            mem[b][2*s +: 2] = 2'(old);
            exp_mem[b] = mem[b];
            rm = old & ~keep; nw = old & keep;
            run_cmd(0, page, keep, wh[0]);
            if (rm == 0) begin
              check("R3 no-change flush", n_fl, 0);
              check("R3 no-change write", n_wr, 0);
              check("R3 no-change upd", n_upd, 0);
            end else if ((old & 2) == 0) begin
              exp_mem[b][2*s +: 2] = 2'(nw);
              check("R4 no flush", n_fl, 0);
              check("R4 upd", n_upd, 1);
              check("R4 perm", last_upd_perm, nw);
            end else begin
              check("R5 flush cycles", n_fl, resp_lat + 1);
              check("R5 flush_all", seen_all, wh);
              check("R5 write in flush", n_wrfl, 0);
              if (wh == 0) begin
                exp_mem[b][2*s +: 2] = 2'(nw);
                check("R6 upd", n_upd, 1);
                check("R6 perm", last_upd_perm, nw);
              end else begin
                for (int i = 0; i < int'(cfg_bound); i++) exp_mem[(int'(cfg_base) + i) % NB] = '0;
                check("R7 inv", n_inv, 1);
                check("R7 tlb", n_tlb, 1);
                check("R7 writes", n_wr, int'(cfg_bound));
                check("R7 no upd", n_upd, 0);
              end
            end
            cmp_mem((rm == 0) ? "R3 mem" : ((old & 2) == 0) ? "R4 mem" : wh ? "R7 mem" : "R6 mem");
          end
        end
      end
    end

    // R8 process complete
    cfg_base = 2; cfg_bound = 4; resp_lat = 3;
    preload(5);
    for (int i = 2; i < 6; i++) exp_mem[i] = '0;
    run_cmd(1, 0, 0, 0);
    check("R8 flush cycles", n_fl, 4);
    check("R8 flush_all", seen_all, 1);
    check("R8 inv", n_inv, 1);
    check("R8 tlb", n_tlb, 1);
    check("R8 writes", n_wr, 4);
    cmp_mem("R8 mem");
    cfg_bound = 0;
    preload(6);
    run_cmd(1, 0, 0, 0);
    check("R8 bound0 writes", n_wr, 0);
    check("R8 bound0 inv", n_inv, 1);
    cmp_mem("R8 bound0 mem");
    cfg_base = 0; cfg_bound = 6;

    // R9 latency sweep around timeout
    cfg_timeout = 5;
    for (int lat = 0; lat < 8; lat++) begin
      int b;
      resp_lat = (lat == 7) ? 1000 : lat;
      b = blk(9);
      preload(lat);
      mem[b][2 +: 2] = 2'b11;
      exp_mem[b] = mem[b];
      exp_mem[b][2 +: 2] = 2'b01;
      run_cmd(0, 9, 1, 0);
      check("R9 flush cycles", n_fl, (resp_lat < 5 ? resp_lat : 5) + 1);
      check("R9 flag", timeout_flag, resp_lat > 5 ? 1 : 0);
      check("R9 upd", n_upd, 1);
      cmp_mem("R9 mem");
    end
    resp_lat = 0;
    preload(1);
    run_cmd(0, 4, 3, 0);
    check("R9 flag cleared", timeout_flag, 0);

    // R2 command while busy is ignored
    resp_lat = 4;
    preload(2);
    mem[blk(0)][1:0] = 2'b11; exp_mem[blk(0)] = mem[blk(0)];
    exp_mem[blk(0)][1:0] = 2'b00;
    mem[blk(20)][1:0] = 2'b01; exp_mem[blk(20)] = mem[blk(20)];
    @(negedge clk);
    clr_counts();
    cmd_valid = 1; cmd_op = 0; cmd_page = 0; cmd_keep = 0; cmd_whole = 0;
    @(negedge clk);
    check("R2 busy", busy, 1);
    cmd_page = 20;
    repeat (2) @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R2 single upd", n_upd, 1);
    check("R2 idle", busy, 0);
    cmp_mem("R2 mem");

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule